// File: doc/BRIEF.md
# Top-of-Range Memory Protection Checker

This block stores a small table of protection entries and classifies each memory access as permitted or faulting. Every entry pairs an 8-bit configuration byte (three permission flags, a two-bit mode and a lock flag) with an upper-bound address register. Four configuration bytes share one 32-bit configuration register. An enabled entry covers the half-open word range that starts at the bound of the entry below it (zero for entry 0) and ends just before its own bound.

A processor core writes and reads the table through a single-cycle register port and drives the checker with a word address, an access kind and the current privilege. The fault output is combinational, so the core sees the verdict in the cycle it presents the access. The core raises the exception itself.

The entry count and the address granularity are parameters. Register slots above the configured count stay addressable: they read as zero and ignore writes.

Top module: `pmp_guard`

## Requirements
- R1: After reset every configuration byte and address register reads zero and no entry matches. Reset is the only way to clear a lock.
- R2: A configuration byte keeps bit 7 (lock), bit 3 (mode LSB) and bits 2:0 (execute, write, read). Bits 6:5 and mode bit 4 always read zero, so a written mode of 10 is stored as 00 (off) and 11 is stored as 01 (top-of-range).
- R3: An address register keeps bits 29 down to log2(GRAN_BYTES)-2. Bits 31:30 and the bits below that range always read zero.
- R4: An entry in mode 01 matches a word address w when lower <= w < upper. The upper bound is the entry's own address register. The lower bound is the address register of the entry below, or zero for entry 0, whatever that entry's mode. An entry in mode 00 never matches.
- R5: On a match, the access kind selects the needed permission. Kind 0 (read) needs bit 0. Kind 1 (write) needs bit 1. Kind 2 (execute) needs bit 2. Kind 3 (read-modify-write) needs bits 0 and 1. The access faults when the permission is missing.
- R6: When several entries match, the lowest-numbered one alone decides.
- R7: A machine-mode access is allowed when nothing matches or when the deciding entry is unlocked. A locked deciding entry applies its permissions to machine mode as well.
- R8: A user-mode access that matches no entry faults.
- R9: While an entry's lock bit is set, writes to that entry's configuration byte and address register are ignored. Its neighbours, including the entry below that supplies its lower bound, stay writable.
- R10: Register slots for entries at or above NUM_ENTRIES, and register addresses 4 to 15, read zero and ignore writes without any error indication.
- R11: Register address map: 0..3 select configuration register k, which holds entries 4k..4k+3 in byte lanes 0..3. 16..31 select the address register of entry (address - 16). A write takes effect at the clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register select (see R11) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational |
| acc_word | input | 30 | Word address of the access (byte address bits 31:2) |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 read-modify-write |
| acc_mmode | input | 1 | 1 = machine mode, 0 = user mode |
| fault | output | 1 | Access is refused |

## Verification
A corrupted configuration byte or bound register shows up on the next combinational read of its register, and on the very next access that falls near the affected range. A wrong verdict reaches the fault pin in the same cycle. A lock that fails to hold is exposed one clock after the blocked write, through the read-back value. A wrong lower-bound link only shows on accesses just below or just above the neighbouring bound, so the stimulus keeps bounds and addresses in a small shared window so that ranges meet and overlap often.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
   localparam int MAX_ENTRIES = 16;
   localparam int CFG_REGS    = MAX_ENTRIES / 4;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RMW   = 2'd3
   } acc_kind_e;

   // keep lock, mode LSB and the three permission flags
   function automatic logic [7:0] legal_cfg(input logic [7:0] raw);
      return {raw[7], 3'b000, raw[3], raw[2:0]};
   endfunction

   function automatic logic perm_ok(input logic [1:0] kind, input logic [7:0] cfg);
      logic ok;
      case (kind)
         ACC_READ:  ok = cfg[0];
         ACC_WRITE: ok = cfg[1];
         ACC_EXEC:  ok = cfg[2];
         default:   ok = cfg[0] & cfg[1];
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/pmp_entry.sv
module pmp_entry #(
   parameter int GRAN_ZB = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [7:0]  cfg_wdata,
   input  logic        bnd_we,
   input  logic [29:0] bnd_wdata,
   input  logic [29:0] lo_bound,
   input  logic [29:0] acc_word,
   output logic [7:0]  cfg_q,
   output logic [29:0] bnd_q,
   output logic        hit
);
   import pmp_pkg::*;

   localparam logic [29:0] BND_MASK = ~((30'd1 << GRAN_ZB) - 30'd1);

   logic locked;
   assign locked = cfg_q[7];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= 8'h00;
         bnd_q <= 30'd0;
      end else if (!locked) begin
         if (cfg_we) cfg_q <= legal_cfg(cfg_wdata);
         if (bnd_we) bnd_q <= bnd_wdata & BND_MASK;
      end
   end

   assign hit = cfg_q[3] && (acc_word >= lo_bound) && (acc_word < bnd_q);
endmodule

// File: rtl/pmp_select.sv
module pmp_select #(
   parameter int N = 16
) (
   input  logic [N-1:0]      hit,
   input  logic [N-1:0][7:0] cfg,
   input  logic [1:0]        acc_kind,
   input  logic              acc_mmode,
   output logic              any_hit,
   output logic              fault
);
   import pmp_pkg::*;

   logic [7:0] win_cfg;

   always_comb begin
      any_hit = 1'b0;
      win_cfg = 8'h00;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any_hit = 1'b1;
            win_cfg = cfg[i];
         end
      end
      if (!any_hit)
         fault = !acc_mmode;
      else if (acc_mmode && !win_cfg[7])
         fault = 1'b0;
      else
         fault = !perm_ok(acc_kind, win_cfg);
   end
endmodule

// File: rtl/pmp_guard.sv
module pmp_guard #(
   parameter int NUM_ENTRIES = 8,
   parameter int GRAN_BYTES  = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_wr,
   input  logic [4:0]  csr_addr,
   input  logic [31:0] csr_wdata,
   output logic [31:0] csr_rdata,
   input  logic [29:0] acc_word,
   input  logic [1:0]  acc_kind,
   input  logic        acc_mmode,
   output logic        fault
);
   import pmp_pkg::*;

   localparam int GRAN_ZB = $clog2(GRAN_BYTES) - 2;

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > MAX_ENTRIES) begin : g_bad_count
      $error("pmp_guard: NUM_ENTRIES out of range");
   end
   if (GRAN_BYTES < 4 || (GRAN_BYTES & (GRAN_BYTES - 1)) != 0) begin : g_bad_gran
      $error("pmp_guard: GRAN_BYTES must be a power of two >= 4");
   end

   logic [MAX_ENTRIES-1:0][7:0]  cfg_q;
   logic [MAX_ENTRIES-1:0][29:0] bnd_q;
   logic [MAX_ENTRIES-1:0]       hit;
   logic                         any_hit;

   for (genvar i = 0; i < MAX_ENTRIES; i++) begin : g_ent
      if (i < NUM_ENTRIES) begin : g_real
         logic        cfg_we_i;
         logic        bnd_we_i;
         logic [29:0] lo_i;
         assign cfg_we_i = csr_wr && (csr_addr == 5'(i / 4));
         assign bnd_we_i = csr_wr && (csr_addr == 5'(16 + i));
         if (i == 0) begin : g_base
            assign lo_i = 30'd0;
         end else begin : g_chain
            assign lo_i = bnd_q[i-1];
         end
         pmp_entry #(.GRAN_ZB(GRAN_ZB)) i_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we_i),
            .cfg_wdata(csr_wdata[8*(i%4) +: 8]),
            .bnd_we   (bnd_we_i),
            .bnd_wdata(csr_wdata[29:0]),
            .lo_bound (lo_i),
            .acc_word (acc_word),
            .cfg_q    (cfg_q[i]),
            .bnd_q    (bnd_q[i]),
            .hit      (hit[i])
         );
      end else begin : g_empty
         assign cfg_q[i] = 8'h00;
         assign bnd_q[i] = 30'd0;
         assign hit[i]   = 1'b0;
      end
   end

   always_comb begin
      csr_rdata = 32'd0;
      if (csr_addr[4])
         csr_rdata = {2'b00, bnd_q[csr_addr[3:0]]};
      else if (csr_addr[3:2] == 2'b00)
         csr_rdata = {cfg_q[{csr_addr[1:0], 2'd3}], cfg_q[{csr_addr[1:0], 2'd2}],
                      cfg_q[{csr_addr[1:0], 2'd1}], cfg_q[{csr_addr[1:0], 2'd0}]};
   end

   pmp_select #(.N(MAX_ENTRIES)) i_select (
      .hit      (hit),
      .cfg      (cfg_q),
      .acc_kind (acc_kind),
      .acc_mmode(acc_mmode),
      .any_hit  (any_hit),
      .fault    (fault)
   );
endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk #(
   parameter int NUM_ENTRIES = 8,
   parameter int GRAN_BYTES  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        csr_addr,
   input logic [31:0]       csr_rdata,
   input logic              acc_mmode,
   input logic              fault,
   input logic              any_hit,
   input logic [15:0][7:0]  cfg_q
);
   localparam int          ZB       = $clog2(GRAN_BYTES) - 2;
   localparam logic [31:0] LOW_MASK = (32'd1 << ZB) - 32'd1;

   // R2: reserved and hardwired configuration bits never read back set
   assert_cfg_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_addr[4] |-> ((csr_rdata & 32'h7070_7070) == 32'd0));

   // R3: bound registers keep their top and sub-granule bits at zero
   assert_bnd_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      csr_addr[4] |-> (csr_rdata[31:30] == 2'b00 && (csr_rdata & LOW_MASK) == 32'd0));

   // R7: machine mode with no matching entry never faults
   assert_mach_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_mmode && !any_hit) |-> !fault);

   // R8: user mode with no matching entry always faults
   assert_user_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_mmode && !any_hit) |-> fault);

   // R10: slots beyond the configured count read zero
   assert_slot_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr[4] && 32'(csr_addr[3:0]) >= NUM_ENTRIES) |-> (csr_rdata == 32'd0));

   // R9: a locked configuration byte does not change until reset
   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_lock
      assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_q[i][7] |=> $stable(cfg_q[i]));
   end
endmodule

bind pmp_guard pmp_guard_chk #(.NUM_ENTRIES(NUM_ENTRIES), .GRAN_BYTES(GRAN_BYTES)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .csr_addr (csr_addr),
   .csr_rdata(csr_rdata),
   .acc_mmode(acc_mmode),
   .fault    (fault),
   .any_hit  (any_hit),
   .cfg_q    (cfg_q)
);

// File: tb/test_pmp_guard.sv
`timescale 1ns/1ps
module test_pmp_guard;
   localparam int NUM  = 8;
   localparam int GRAN = 16;
   localparam int ZB   = $clog2(GRAN) - 2;
   localparam logic [29:0] MASK = ~((30'd1 << ZB) - 30'd1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [4:0]  csr_addr = 5'd0;
   logic [31:0] csr_wdata = 32'd0;
   logic [31:0] csr_rdata;
   logic [29:0] acc_word = 30'd0;
   logic [1:0]  acc_kind = 2'd0;
   logic        acc_mmode = 1'b0;
   logic        fault;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0]  m_cfg [16];
   logic [29:0] m_bnd [16];

   always #2 clk = ~clk;

   pmp_guard #(.NUM_ENTRIES(NUM), .GRAN_BYTES(GRAN)) i_pmp_guard (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .acc_word(acc_word),
      .acc_kind(acc_kind), .acc_mmode(acc_mmode), .fault(fault));

   function automatic logic [31:0] model_rd(input logic [4:0] a);
      logic [31:0] v = 32'd0;
      if (a[4]) begin
         if (int'(a[3:0]) < NUM) v = {2'b00, m_bnd[a[3:0]]};
      end else if (a[3:2] == 2'b00) begin
         for (int j = 0; j < 4; j++)
            if (int'(a[1:0]) * 4 + j < NUM) v[8*j +: 8] = m_cfg[int'(a[1:0]) * 4 + j];
      end
      return v;
   endfunction

   function automatic void model_wr(input logic [4:0] a, input logic [31:0] d);
      if (a[4]) begin
         if (int'(a[3:0]) < NUM && !m_cfg[a[3:0]][7]) m_bnd[a[3:0]] = d[29:0] & MASK;
      end else if (a[3:2] == 2'b00) begin
         for (int j = 0; j < 4; j++) begin
            int k = int'(a[1:0]) * 4 + j;
            if (k < NUM && !m_cfg[k][7])
               m_cfg[k] = {d[8*j+7], 3'b000, d[8*j+3], d[8*j +: 3]};
         end
      end
   endfunction

   function automatic logic model_fault(input logic [29:0] w, input logic [1:0] kind, input logic mm);
      for (int i = 0; i < NUM; i++) begin
         logic [29:0] lo = (i == 0) ? 30'd0 : m_bnd[i-1];
         if (m_cfg[i][3] && w >= lo && w < m_bnd[i]) begin
            logic ok;
            if (mm && !m_cfg[i][7]) return 1'b0;
            case (kind)
               2'd0: ok = m_cfg[i][0];
               2'd1: ok = m_cfg[i][1];
               2'd2: ok = m_cfg[i][2];
               default: ok = m_cfg[i][0] & m_cfg[i][1];
            endcase
            return !ok;
         end
      end
      return !mm;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         m_cfg[i] = 8'h00;
         m_bnd[i] = 30'd0;
      end
      rst_n = 1'b1;
   endtask

   task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
      model_wr(a, d);
   endtask

   task automatic rd_model(input logic [4:0] a, input string tag);
      csr_addr = a;
      #1;
      check(tag, csr_rdata, model_rd(a));
   endtask

   task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string tag);
      csr_addr = a;
      #1;
      check(tag, csr_rdata, e);
   endtask

   task automatic acc(input logic [29:0] w, input logic [1:0] k, input logic mm, input string tag);
      acc_word = w; acc_kind = k; acc_mmode = mm;
      #1;
      check(tag, 32'(fault), 32'(model_fault(w, k, mm)));
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      do_reset();
      // R1 reset state
      rd_exp(5'd0, 32'd0, "R1 cfg0");
      rd_exp(5'd1, 32'd0, "R1 cfg1");
      rd_exp(5'd16, 32'd0, "R1 bnd0");
      acc(30'h40, 2'd0, 1'b0, "R1 user denied");
      acc(30'h40, 2'd1, 1'b1, "R1 machine free");
      // R2 legalisation: 0x77 -> 0x07, 0x1E -> 0x0E
      do_wr(5'd0, 32'h0000_1E77);
      rd_exp(5'd0, 32'h0000_0E07, "R2 legal");
      // R3 bound masking
      do_wr(5'd16, 32'hFFFF_FFFF);
      rd_exp(5'd16, 32'h3FFF_FFFC, "R3 mask");
      // R4/R5: entry0 [0,0x100) R; entry1 [0x100,0x200) RW
      do_wr(5'd16, 32'h100);
      do_wr(5'd17, 32'h200);
      do_wr(5'd0, 32'h0000_0B09);
      acc(30'hFF,  2'd0, 1'b0, "R4 top of entry0");
      acc(30'h100, 2'd0, 1'b0, "R4 base of entry1");
      acc(30'h100, 2'd1, 1'b0, "R5 write entry1");
      acc(30'hFF,  2'd1, 1'b0, "R5 write entry0");
      acc(30'h150, 2'd2, 1'b0, "R5 exec entry1");
      acc(30'h150, 2'd3, 1'b0, "R5 rmw entry1");
      acc(30'h10,  2'd3, 1'b0, "R5 rmw entry0");
      acc(30'h200, 2'd0, 1'b0, "R8 past top");
      acc(30'h200, 2'd1, 1'b1, "R7 machine nomatch");
      acc(30'h10,  2'd1, 1'b1, "R7 machine unlocked");
      // R6: entry2 [0x80,0x300) exec only overlaps entry0 after bound1 drop
      do_wr(5'd17, 32'h80);
      do_wr(5'd18, 32'h300);
      do_wr(5'd0, 32'h000C_0B09);
      acc(30'h90,  2'd0, 1'b0, "R6 lowest wins");
      acc(30'h150, 2'd0, 1'b0, "R6 entry2 only");
      acc(30'h150, 2'd2, 1'b0, "R6 entry2 exec");
      // R9 lock entry4, entry3 stays writable
      do_wr(5'd19, 32'h450);
      do_wr(5'd20, 32'h500);
      do_wr(5'd1, 32'h0000_0089);
      do_wr(5'd1, 32'h0000_0F00);
      rd_exp(5'd1, 32'h0000_0F89, "R9 cfg locked");
      do_wr(5'd20, 32'h123);
      rd_exp(5'd20, 32'h0000_0500, "R9 bound locked");
      do_wr(5'd19, 32'h460);
      rd_exp(5'd19, 32'h0000_0460, "R9 neighbour writable");
      acc(30'h470, 2'd1, 1'b1, "R7 locked machine write");
      acc(30'h470, 2'd0, 1'b1, "R7 locked machine read");
      // R10 unimplemented slots
      do_wr(5'd25, 32'h777);
      rd_exp(5'd25, 32'd0, "R10 bnd9");
      do_wr(5'd2, 32'h0F0F_0F0F);
      rd_exp(5'd2, 32'd0, "R10 cfg2");
      rd_exp(5'd5, 32'd0, "R10 hole");
      rd_exp(5'd0, 32'h000C_0B09, "R11 map cfg0");
      // random mix
      for (int it = 0; it < 4000; it++) begin
         int op = int'($urandom % 10);
         if (op < 3) begin
            logic [4:0] a;
            logic [31:0] d;
            if ($urandom % 2 == 0) begin
               a = 5'($urandom % 4);
               d = $urandom;
               if ($urandom % 8 != 0) d = d & 32'h7F7F_7F7F;
            end else begin
               a = 5'(16 + $urandom % 16);
               d = $urandom % 1024;
            end
            do_wr(a, d);
         end else if (op < 5) begin
            rd_model(5'($urandom % 32), "R11 random read");
         end else begin
            acc(30'($urandom % 1100), 2'($urandom % 4), 1'($urandom % 2), "R4 random access");
         end
      end
      // R1 reset clears locks
      do_reset();
      rd_exp(5'd1, 32'd0, "R1 lock cleared");
      acc(30'h470, 2'd1, 1'b0, "R1 user denied after reset");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule